// File: doc/BRIEF.md
# Power-On Serial Configuration Image Loader

This block runs a single read of a configuration image from an external serial EEPROM as soon as the chip comes out of reset. It waits a fixed settling time after the internal reset is released, samples two strap inputs, and, if both are high, acts as an I2C master. It issues a start, the device address with the read bit, and a sequential current-address read of a fixed number of bytes, then a stop. The bus clock is the reference clock divided by a parameter (384 by default, about 31 kHz from 12 MHz). Both bus lines are open drain: the block only ever pulls a line low or releases it.

The image holds a vendor ID and product ID (low byte first), a 16-byte product name, a 32-byte vendor name, a power attribute byte, a maximum-power byte and a three-byte auxiliary usage code, for 57 bytes in total. The EEPROM sends each byte MSB first, but the image is stored with the bits reversed, so the first bit seen on the bus becomes bit 0 of the stored byte. Surrounding logic holds off every host request while `busy_o` is high. It reads the image through a combinational byte port, and uses `img_valid_o` to choose between the loaded image and its own built-in default. If the strap inputs are not both high, or the EEPROM does not acknowledge its address, the built-in default stays in use.

Top module: `cfg_image_loader`

## Requirements
- R1: From reset, `busy_o` is high and `done_o`, `error_o` and `img_valid_o` are low; `busy_o` stays high until the loader finishes.
- R2: For STARTUP_WAIT cycles after reset release both bus lines stay released; the start condition begins in the cycle that follows the STARTUP_WAIT-th clock edge with reset low.
- R3: The straps are sampled at the end of the wait. Unless `pwr_sel_i` and `host_att_i` are both high, the loader goes straight to done, with no bus activity, `error_o` low and `img_valid_o` low.
- R4: Each bus element (start, bit or stop) lasts CLK_DIV cycles, split into four equal quarters. In a bit element SCL is pulled low in quarters 0 and 3 and released in quarters 1 and 2, so its period is CLK_DIV.
- R5: The start element releases SDA for quarters 0–1 and pulls it low for quarters 2–3, and SCL goes low in quarter 3. Then the address byte {DEV_ADDR, 1} (0xA1 by default) is sent MSB first, and SDA is released in the ninth slot for the slave acknowledge.
- R6: The master pulls SDA low in the ninth slot of every data byte except the last, releases it (NACK) after the last byte, and then sends a stop: SDA low in quarters 0–1, released in quarters 2–3, SCL low only in quarter 0.
- R7: Exactly IMG_BYTES data bytes are read. With a full load, done rises after 2 + 9·(IMG_BYTES+1) elements.
- R8: The first data bit received for a byte is stored as bit 0 and the last as bit 7. Byte k of the image holds the k-th byte read.
- R9: If the address is not acknowledged, a stop follows at once. At the end of that stop `done_o` and `error_o` rise together, `busy_o` falls, and `img_valid_o` stays low.
- R10: SDA changes while SCL is released only inside a start or a stop. SDA is sampled at the end of quarter 1, the middle of the SCL high phase.
- R11: After a full load `img_valid_o` is high and `rd_data_o` returns the stored byte at `rd_addr_i`. An address at or above IMG_BYTES returns 0x00.
- R12: Once done, the loader stays done with both lines released until the next reset; `done_o` rises in the cycle after the last quarter of the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (internal reset release) |
| pwr_sel_i | input | 1 | Power-source strap; must be high to load |
| host_att_i | input | 1 | Host-attach strap; must be high to load |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_low_o | output | 1 | Pull SCL low when 1, release when 0 |
| sda_low_o | output | 1 | Pull SDA low when 1, release when 0 |
| busy_o | output | 1 | Loader active; host requests must be refused |
| done_o | output | 1 | Loader finished (any outcome) |
| error_o | output | 1 | Address byte was not acknowledged |
| img_valid_o | output | 1 | Image was loaded from the EEPROM |
| rd_addr_i | input | $clog2(IMG_BYTES) | Image byte address |
| rd_data_o | output | 8 | Image byte at rd_addr_i |

## Verification
Every bus and status output is a combinational decode of registered state, so a change takes effect in the cycle right after the clock edge that moves the state. The bench counts clock edges since reset release. From that count its model derives the element, the quarter and the expected level of every output, and it compares them at each falling edge: the start is due STARTUP_WAIT edges after release, and each element lasts exactly CLK_DIV cycles. The modelled EEPROM changes its data bit at the falling edge of the first cycle of each element, while SCL is low. The loader samples at the end of quarter 1. The read port is combinational, so the image is read back once the loader is done, with the value checked one time step after the address is applied.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_START,
        ST_ADDR,
        ST_DATA,
        ST_STOP,
        ST_DONE
    } ldr_state_e;

    // Open-drain pad request: 1 pulls the line low
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pad_drv_t;

    localparam logic [3:0] ACK_SLOT = 4'd8;
    localparam logic [1:0] Q_SAMPLE = 2'd1;
    localparam logic [1:0] Q_LAST   = 2'd3;

    function automatic logic [7:0] read_addr_byte(input logic [6:0] dev);
        return {dev, 1'b1};
    endfunction

    // SCL is released in the two middle quarters of a bit element
    function automatic logic bit_scl_low(input logic [1:0] q);
        return (q == 2'd0) || (q == 2'd3);
    endfunction

endpackage

// File: rtl/ldr_phase_gen.sv
module ldr_phase_gen #(
    parameter int QTR = 96
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    output logic       tick,
    output logic [1:0] quarter
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= '0;
            quarter <= 2'd0;
        end else if (cnt == CW'(QTR - 1)) begin
            cnt     <= '0;
            quarter <= quarter + 2'd1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(QTR - 1));

endmodule

// File: rtl/ldr_fsm.sv
module ldr_fsm
    import ldr_pkg::*;
#(
    parameter int         IMG_BYTES    = 57,
    parameter int         STARTUP_WAIT = 8400,
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    localparam int        AW           = $clog2(IMG_BYTES),
    localparam int        WW           = $clog2(STARTUP_WAIT + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_sel,
    input  logic            host_att,
    input  logic            sda_in,
    input  logic            tick,
    input  logic [1:0]      quarter,
    output logic            run,
    output ldr_state_e      state,
    output pad_drv_t        pad,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [7:0]      wr_data,
    output logic            err,
    output logic            valid
);
    localparam logic [7:0] ADDR_B = read_addr_byte(DEV_ADDR);

    logic [WW-1:0] wcnt;
    logic [3:0]    bit_idx;
    logic [AW-1:0] byte_idx;
    logic [7:0]    shreg;
    logic          ack_ok;
    logic          last_byte;
    logic          elem_end;
    logic          sample;
    logic [7:0]    shifted;

    assign last_byte = (byte_idx == AW'(IMG_BYTES - 1));
    assign elem_end  = tick && (quarter == Q_LAST);
    assign sample    = tick && (quarter == Q_SAMPLE);
    // first bus bit ends in bit 0 after eight right shifts
    assign shifted   = {sda_in, shreg[7:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_WAIT;
            wcnt     <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            ack_ok   <= 1'b0;
            err      <= 1'b0;
            valid    <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (state)
                ST_WAIT: begin
                    if (wcnt == WW'(STARTUP_WAIT - 1)) begin
                        state <= (pwr_sel && host_att) ? ST_START : ST_DONE;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_START: begin
                    if (elem_end) begin
                        state   <= ST_ADDR;
                        bit_idx <= '0;
                    end
                end
                ST_ADDR: begin
                    if (sample && bit_idx == ACK_SLOT) begin
                        ack_ok <= ~sda_in;
                    end
                    if (elem_end) begin
                        if (bit_idx == ACK_SLOT) begin
                            bit_idx  <= '0;
                            byte_idx <= '0;
                            state    <= ack_ok ? ST_DATA : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (sample && bit_idx != ACK_SLOT) begin
                        shreg <= shifted;
                        if (bit_idx == 4'd7) begin
                            wr_en   <= 1'b1;
                            wr_addr <= byte_idx;
                            wr_data <= shifted;
                        end
                    end
                    if (elem_end) begin
                        if (bit_idx == ACK_SLOT) begin
                            bit_idx <= '0;
                            if (last_byte) begin
                                state <= ST_STOP;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (elem_end) begin
                        state <= ST_DONE;
                        if (ack_ok) begin
                            valid <= 1'b1;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign run = (state == ST_START) || (state == ST_ADDR) ||
                 (state == ST_DATA)  || (state == ST_STOP);

    always_comb begin
        pad = '0;
        unique case (state)
            ST_START: begin
                pad.scl_low = (quarter == 2'd3);
                pad.sda_low = quarter[1];
            end
            ST_ADDR: begin
                pad.scl_low = bit_scl_low(quarter);
                pad.sda_low = (bit_idx == ACK_SLOT) ? 1'b0
                                                    : ~ADDR_B[3'd7 - bit_idx[2:0]];
            end
            ST_DATA: begin
                pad.scl_low = bit_scl_low(quarter);
                pad.sda_low = (bit_idx == ACK_SLOT) && !last_byte;
            end
            ST_STOP: begin
                pad.scl_low = (quarter == 2'd0);
                pad.sda_low = !quarter[1];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ldr_image.sv
module ldr_image #(
    parameter int  IMG_BYTES = 57,
    localparam int AW        = $clog2(IMG_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] bytes_w [IMG_BYTES];

    for (genvar i = 0; i < IMG_BYTES; i++) begin : g_byte
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && wr_addr == AW'(i)) begin
                q <= wr_data;
            end
        end
        assign bytes_w[i] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < IMG_BYTES; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = bytes_w[i];
            end
        end
    end

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import ldr_pkg::*;
#(
    parameter int         CLK_DIV      = 384,
    parameter int         IMG_BYTES    = 57,
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    parameter int         STARTUP_WAIT = 8400
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pwr_sel_i,
    input  logic                         host_att_i,
    input  logic                         sda_i,
    output logic                         scl_low_o,
    output logic                         sda_low_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         error_o,
    output logic                         img_valid_o,
    input  logic [$clog2(IMG_BYTES)-1:0] rd_addr_i,
    output logic [7:0]                   rd_data_o
);
    localparam int QTR = CLK_DIV / 4;
    localparam int AW  = $clog2(IMG_BYTES);

    logic          run;
    logic          tick;
    logic [1:0]    quarter;
    ldr_state_e    fsm_state;
    pad_drv_t      pad;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          err;
    logic          valid;

    ldr_phase_gen #(.QTR(QTR)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick    (tick),
        .quarter (quarter)
    );

    ldr_fsm #(
        .IMG_BYTES    (IMG_BYTES),
        .STARTUP_WAIT (STARTUP_WAIT),
        .DEV_ADDR     (DEV_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwr_sel  (pwr_sel_i),
        .host_att (host_att_i),
        .sda_in   (sda_i),
        .tick     (tick),
        .quarter  (quarter),
        .run      (run),
        .state    (fsm_state),
        .pad      (pad),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .err      (err),
        .valid    (valid)
    );

    ldr_image #(.IMG_BYTES(IMG_BYTES)) u_image (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr_i),
        .rd_data (rd_data_o)
    );

    assign scl_low_o   = pad.scl_low;
    assign sda_low_o   = pad.sda_low;
    assign busy_o      = (fsm_state != ST_DONE);
    assign done_o      = (fsm_state == ST_DONE);
    assign error_o     = err;
    assign img_valid_o = valid;

endmodule

// File: rtl/ldr_checker.sv
module ldr_checker
    import ldr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input ldr_state_e st,
    input logic       scl_low,
    input logic       sda_low,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       img_valid
);

    // R2: bus stays released while the startup wait runs
    p_quiet_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (!scl_low && !sda_low));

    // R4: SCL is only pulled while the loader is busy
    p_scl_busy_r4: assert property (@(posedge clk) disable iff (rst)
        scl_low |-> busy);

    // R10: SDA moves under a released SCL only for start or stop
    p_sda_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!scl_low && $past(!scl_low) && !$stable(sda_low))
            |-> (st == ST_START || st == ST_STOP));

    // R9: the error flag appears only together with done
    p_err_done_r9: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    // R11: a valid image excludes the error outcome
    p_valid_ok_r11: assert property (@(posedge clk) disable iff (rst)
        img_valid |-> (done && !error));

    // R12: done is sticky and leaves the lines released
    p_done_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (!scl_low && !sda_low));

endmodule

bind cfg_image_loader ldr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (fsm_state),
    .scl_low   (scl_low_o),
    .sda_low   (sda_low_o),
    .busy      (busy_o),
    .done      (done_o),
    .error     (error_o),
    .img_valid (img_valid_o)
);

// File: tb/sim_cfg_image_loader.sv
module sim_cfg_image_loader;

    localparam int         DIV    = 16;
    localparam int         Q      = DIV / 4;
    localparam int         N      = 57;
    localparam int         W      = 10;
    localparam logic [6:0] DEV    = 7'h50;
    localparam logic [7:0] ADDR_B = {DEV, 1'b1};
    localparam int         E_LOAD = 2 + 9 * (N + 1);
    localparam int         E_NACK = 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr = 1'b0;
    logic       host = 1'b0;
    logic       slave_low = 1'b0;
    logic [5:0] rd_addr = '0;

    wire       scl_low, sda_low, busy, done, err, valid;
    wire [7:0] rd_data;
    wire       sda_line = !(sda_low || slave_low);

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cfg_image_loader #(
        .CLK_DIV      (DIV),
        .IMG_BYTES    (N),
        .DEV_ADDR     (DEV),
        .STARTUP_WAIT (W)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .pwr_sel_i   (pwr),
        .host_att_i  (host),
        .sda_i       (sda_line),
        .scl_low_o   (scl_low),
        .sda_low_o   (sda_low),
        .busy_o      (busy),
        .done_o      (done),
        .error_o     (err),
        .img_valid_o (valid),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data)
    );

    function automatic logic [7:0] eeprom(input int b);
        return 8'(((b * 37) + 11) ^ (b << 3));
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7 - i];
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)",
                     req, what, act, exp, $time);
        end
    endtask

    // mode 0: full load, 1: straps block load, 2: address not acknowledged
    task automatic ref_model(input int mode, input int n,
                             output logic [5:0] e, output logic sl,
                             output string lab_bus, output string lab_end);
        logic b, d, er, v, sc, sd;
        int t, el, q, k, by, bi, total;
        sl = 1'b0; sc = 1'b0; sd = 1'b0;
        lab_bus = "R5"; lab_end = "R1";
        if (n < W) begin
            b = 1; d = 0; er = 0; v = 0; lab_bus = "R2";
        end else if (mode == 1) begin
            b = 0; d = 1; er = 0; v = 0; lab_bus = "R3"; lab_end = "R3";
        end else begin
            t = n - W;
            total = (mode == 0) ? E_LOAD : E_NACK;
            if (t >= total * DIV) begin
                b = 0; d = 1; er = (mode == 2); v = (mode == 0);
                lab_bus = "R12";
                lab_end = (mode == 0) ? "R7" : "R9";
            end else begin
                b = 1; d = 0; er = 0; v = 0;
                el = t / DIV;
                q  = (t % DIV) / Q;
                if (el == 0) begin
                    sc = (q == 3); sd = (q >= 2);
                end else if (el == total - 1) begin
                    sc = (q == 0); sd = (q <= 1); lab_bus = "R6";
                end else begin
                    sc = (q == 0 || q == 3);
                    if (!sc) lab_bus = "R10";
                    k = el - 1;
                    if (k < 9) begin
                        if (k < 8) sd = !ADDR_B[7 - k];
                        else begin
                            sd = 1'b0;
                            sl = (mode == 0);
                        end
                    end else begin
                        k  = k - 9;
                        by = k / 9;
                        bi = k % 9;
                        if (bi < 8) begin
                            sd = 1'b0;
                            sl = !eeprom(by)[7 - bi];
                        end else begin
                            sd = (by != N - 1);
                            lab_bus = "R6";
                        end
                    end
                end
            end
        end
        e = {b, d, er, v, sc, sd};
    endtask

    task automatic run_case(input int mode, input logic p, input logic h,
                            input int ncycles);
        logic [5:0] e;
        logic sl;
        string lb, le;
        rst = 1'b1; pwr = p; host = h; slave_low = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n <= ncycles; n++) begin
            ref_model(mode, n, e, sl, lb, le);
            if (n == 0) chk("R1", "busy after reset", 32'(busy), 32'(1));
            chk(le, "busy", 32'(busy), 32'(e[5]));
            chk(le, "done", 32'(done), 32'(e[4]));
            chk("R9", "error", 32'(err), 32'(e[3]));
            chk("R11", "img_valid", 32'(valid), 32'(e[2]));
            chk((lb == "R5") ? "R4" : lb, "scl_low", 32'(scl_low), 32'(e[1]));
            chk(lb, "sda_low", 32'(sda_low), 32'(e[0]));
            slave_low = sl;
            @(negedge clk);
        end
        slave_low = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        // full load and image readback
        run_case(0, 1'b1, 1'b1, W + E_LOAD * DIV + 30);
        for (int i = 0; i < N; i++) begin
            rd_addr = 6'(i);
            #1;
            chk("R8", "image byte", 32'(rd_data), 32'(rev8(eeprom(i))));
        end
        rd_addr = 6'(N);
        #1;
        chk("R11", "read past end", 32'(rd_data), 32'(0));
        rd_addr = 6'd63;
        #1;
        chk("R11", "read top address", 32'(rd_data), 32'(0));
        rd_addr = '0;

        // strap combinations that block the load
        run_case(1, 1'b0, 1'b1, W + 30);
        run_case(1, 1'b1, 1'b0, W + 30);
        run_case(1, 1'b0, 1'b0, W + 30);

        // address not acknowledged
        run_case(2, 1'b1, 1'b1, W + E_NACK * DIV + 30);
        rd_addr = '0;
        #1;
        chk("R9", "image untouched", 32'(rd_data), 32'(0));

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule